// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block turns a command word written through a simple register write port into one transaction on an abstract card port. It decodes the word into a command index and a set of option flags, then presents the index and the stored argument to the card with a valid/ready handshake. The card answers with a response strobe that carries a byte length, the response bytes, or an error flag. The sequencer checks the length against the response type that was asked for. When the length matches, it fills four 32-bit response registers. It then emits a one-cycle set pulse toward an interrupt status block: command-complete on success, no-response on failure.

A command word may also ask for an automatic stop. When the data path reports that the remaining transfer count has reached zero, the sequencer sends stop index 12 with argument 0. The stored command word and argument stay visible and unchanged throughout. When the stop's response arrives, an extra auto-command-done pulse is emitted. A command word flagged as a clock change completes at once and never reaches the card.

Top module: `sdseq_top`

## Requirements
- R1: A write to the command word while idle stores it with the start bit (bit 31) cleared. If bit 31 of the written value was set, the sequencer requests the card with index = bits [5:0] of the word and the stored argument.
- R2: A started command with bit 21 set makes no card request. One cycle after the write, status bit 2 (command-complete) pulses.
- R3: With bit 6 set and bit 7 clear, a 4-byte response places response bytes 0..3, read big-endian, in response register 0 and clears registers 1..3. Response byte k sits at data bits [127-8k -: 8], and register j sits at rsp_words[32j +: 32].
- R4: With bits 6 and 7 set, a 16-byte response fills the registers word-reversed. Register 0 takes bytes 12..15 and register 3 takes bytes 0..3, each read big-endian.
- R5: A response error flag, or a length that does not match the requested response type, pulses status bit 1 (no-response) in place of bit 2 and leaves the response registers unchanged.
- R6: With bit 6 clear, any non-error response pulses bit 2 and leaves the response registers unchanged.
- R7: If the stored word has bit 12 set when xfer_zero is seen, the sequencer requests index 12 with argument 0. The stored word and argument read back unchanged. Status bit 14 pulses together with that stop's completion or no-response pulse.
- R8: xfer_zero has no effect while bit 12 of the stored word is clear.
- R9: While busy, writes to the command word and the argument are ignored, start trigger included.
- R10: A card request holds its valid, index and argument stable until it is accepted.
- R11: Status pulses last one cycle and appear in the cycle after the response strobe is taken. Bits 1 and 2 are never set together.
- R12: After reset the command word, argument and response registers are zero, the block is idle and no request or status is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write value |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument write value |
| xfer_zero | input | 1 | Remaining transfer count reached zero (pulse) |
| card_req_valid | output | 1 | Request to the card is valid |
| card_req_ready | input | 1 | Card accepts the request |
| card_idx | output | 6 | Command index sent to the card |
| card_arg | output | 32 | Argument sent to the card |
| card_rsp_valid | input | 1 | Card response strobe |
| card_rsp_err | input | 1 | Card did not answer |
| card_rsp_len | input | 5 | Response length in bytes |
| card_rsp_data | input | 128 | Response bytes, byte 0 in the top bits |
| cmd_word | output | 32 | Stored command word |
| cmd_arg | output | 32 | Stored argument |
| rsp_words | output | 128 | Response registers, register j at [32j +: 32] |
| busy | output | 1 | A command or pending stop is in progress |
| sts_set | output | 16 | One-cycle status set pulses (bits 1, 2, 14) |

## Verification
The assertions assume that the card raises its response strobe only after it has accepted a request, and only once for that request. They also assume that xfer_zero comes as a single pulse and not on the cycle a pending stop is launched. The bench card model keeps to this. It answers exactly one negative clock edge after it observes an accepted request, and the bench pulses xfer_zero only once the sequencer is idle. Stalls on the ready input and writes made while busy are driven on purpose, inside these limits.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
    // command word flag positions (decoded by software-facing logic next door)
    localparam int CMD_LOAD_BIT     = 31;
    localparam int CMD_CLKCHG_BIT   = 21;
    localparam int CMD_AUTOSTOP_BIT = 12;
    localparam int CMD_RSPLONG_BIT  = 7;
    localparam int CMD_RSPEXP_BIT   = 6;

    // status set vector, positions shared with the interrupt status block
    localparam int STS_W         = 16;
    localparam int STS_NORSP_BIT = 1;
    localparam int STS_DONE_BIT  = 2;
    localparam int STS_AUTO_BIT  = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic clkchg;
        logic autostop;
        logic rsp_exp;
        logic rsp_long;
    } cmd_flags_t;
endpackage

// File: rtl/sdseq_decode.sv
module sdseq_decode
    import sdseq_pkg::*;
#(
    parameter int CMD_W = 32,
    parameter int IDX_W = 6
) (
    input  logic [CMD_W-1:0] word,
    output cmd_flags_t       flags,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        flags.load     = word[CMD_LOAD_BIT];
        flags.clkchg   = word[CMD_CLKCHG_BIT];
        flags.autostop = word[CMD_AUTOSTOP_BIT];
        flags.rsp_exp  = word[CMD_RSPEXP_BIT];
        flags.rsp_long = word[CMD_RSPLONG_BIT];
        idx            = word[IDX_W-1:0];
    end
endmodule

// File: rtl/sdseq_rsp_check.sv
module sdseq_rsp_check #(
    parameter int DATA_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = 5,
    localparam int RSP_W    = DATA_W * RSP_WORDS
) (
    input  logic             rsp_exp,
    input  logic             rsp_long,
    input  logic             err,
    input  logic [LEN_W-1:0] len,
    input  logic [RSP_W-1:0] data,
    output logic             ok,
    output logic             upd,
    output logic [RSP_W-1:0] image
);
    localparam int SHORT_BYTES = DATA_W / 8;
    localparam int LONG_BYTES  = RSP_W / 8;

    logic len_short, len_long;

    assign len_short = (int'(len) == SHORT_BYTES);
    assign len_long  = (int'(len) == LONG_BYTES);

    always_comb begin
        ok  = 1'b0;
        upd = 1'b0;
        if (!err) begin
            if (!rsp_exp) begin
                ok = 1'b1;
            end else if (rsp_long ? len_long : len_short) begin
                ok  = 1'b1;
                upd = 1'b1;
            end
        end
    end

    // register j: long -> big-endian word (RSP_WORDS-1-j), which sits at [j*DATA_W +: DATA_W];
    // short -> register 0 takes the first word, the others clear
    for (genvar j = 0; j < RSP_WORDS; j++) begin : g_word
        if (j == 0) begin : g_first
            assign image[DATA_W-1:0] = rsp_long ? data[DATA_W-1:0]
                                                : data[RSP_W-1 -: DATA_W];
        end else begin : g_rest
            assign image[j*DATA_W +: DATA_W] = rsp_long ? data[j*DATA_W +: DATA_W]
                                                        : '0;
        end
    end
endmodule

// File: rtl/sdseq_top.sv
module sdseq_top
    import sdseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 6,
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = 5,
    parameter int STOP_IDX  = 12,
    localparam int RSP_W    = DATA_W * RSP_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              arg_wr,
    input  logic [DATA_W-1:0] arg_wdata,
    input  logic              xfer_zero,
    output logic              card_req_valid,
    input  logic              card_req_ready,
    output logic [IDX_W-1:0]  card_idx,
    output logic [DATA_W-1:0] card_arg,
    input  logic              card_rsp_valid,
    input  logic              card_rsp_err,
    input  logic [LEN_W-1:0]  card_rsp_len,
    input  logic [RSP_W-1:0]  card_rsp_data,
    output logic [DATA_W-1:0] cmd_word,
    output logic [DATA_W-1:0] cmd_arg,
    output logic [RSP_W-1:0]  rsp_words,
    output logic              busy,
    output logic [STS_W-1:0]  sts_set
);
    typedef struct packed {
        seq_state_e        st;
        logic              stop_pend;
        logic              is_stop;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] arg;
        logic [RSP_W-1:0]  rsp;
        logic [STS_W-1:0]  sts;
    } seq_t;

    seq_t q, d;

    cmd_flags_t       wr_flags, cur_flags;
    logic [IDX_W-1:0] wr_idx, cur_idx;
    logic             chk_ok, chk_upd;
    logic [RSP_W-1:0] chk_image;
    logic             busy_int;

    // decode of the incoming write and of the stored word
    sdseq_decode #(.CMD_W(DATA_W), .IDX_W(IDX_W)) u_dec_wr (
        .word (cmd_wdata),
        .flags(wr_flags),
        .idx  (wr_idx)
    );

    sdseq_decode #(.CMD_W(DATA_W), .IDX_W(IDX_W)) u_dec_cur (
        .word (q.cmd),
        .flags(cur_flags),
        .idx  (cur_idx)
    );

    sdseq_rsp_check #(.DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)) u_chk_rsp (
        .rsp_exp (cur_flags.rsp_exp),
        .rsp_long(cur_flags.rsp_long),
        .err     (card_rsp_err),
        .len     (card_rsp_len),
        .data    (card_rsp_data),
        .ok      (chk_ok),
        .upd     (chk_upd),
        .image   (chk_image)
    );

    assign busy_int = (q.st != ST_IDLE) || q.stop_pend;

    always_comb begin
        d     = q;
        d.sts = '0;

        if (xfer_zero && cur_flags.autostop) begin
            d.stop_pend = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (q.stop_pend) begin
                    d.st        = ST_REQ;
                    d.is_stop   = 1'b1;
                    d.stop_pend = 1'b0;
                end else begin
                    if (arg_wr) begin
                        d.arg = arg_wdata;
                    end
                    if (cmd_wr) begin
                        d.cmd                = cmd_wdata;
                        d.cmd[CMD_LOAD_BIT]  = 1'b0;
                        if (wr_flags.load) begin
                            d.is_stop = 1'b0;
                            if (wr_flags.clkchg) begin
                                d.sts[STS_DONE_BIT] = 1'b1;
                            end else begin
                                d.st = ST_REQ;
                            end
                        end
                    end
                end
            end
            ST_REQ: begin
                if (card_req_ready) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (card_rsp_valid) begin
                    d.st = ST_IDLE;
                    if (chk_ok) begin
                        d.sts[STS_DONE_BIT] = 1'b1;
                        if (chk_upd) begin
                            d.rsp = chk_image;
                        end
                    end else begin
                        d.sts[STS_NORSP_BIT] = 1'b1;
                    end
                    if (q.is_stop) begin
                        d.sts[STS_AUTO_BIT] = 1'b1;
                    end
                    d.is_stop = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign card_req_valid = (q.st == ST_REQ);
    assign card_idx       = q.is_stop ? IDX_W'(STOP_IDX) : cur_idx;
    assign card_arg       = q.is_stop ? '0 : q.arg;
    assign cmd_word       = q.cmd;
    assign cmd_arg        = q.arg;
    assign rsp_words      = q.rsp;
    assign busy           = busy_int;
    assign sts_set        = q.sts;
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk
    import sdseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              card_req_valid,
    input logic              card_req_ready,
    input logic [IDX_W-1:0]  card_idx,
    input logic [DATA_W-1:0] card_arg,
    input logic [DATA_W-1:0] cmd_word,
    input logic [DATA_W-1:0] cmd_arg,
    input logic              busy,
    input logic [STS_W-1:0]  sts_set
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_valid && !card_req_ready |=> card_req_valid && $stable(card_idx) && $stable(card_arg)); // R10

    AST_STS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_set[STS_DONE_BIT] && sts_set[STS_NORSP_BIT])); // R11

    AST_AUTO_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        sts_set[STS_AUTO_BIT] |-> (sts_set[STS_DONE_BIT] || sts_set[STS_NORSP_BIT])); // R7

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_word) && $stable(cmd_arg)); // R9

    AST_LOAD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_word[CMD_LOAD_BIT]); // R1
endmodule

bind sdseq_top sdseq_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sdseq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .card_req_valid(card_req_valid),
    .card_req_ready(card_req_ready),
    .card_idx      (card_idx),
    .card_arg      (card_arg),
    .cmd_word      (cmd_word),
    .cmd_arg       (cmd_arg),
    .busy          (busy),
    .sts_set       (sts_set)
);

// File: tb/sdseq_top_tb.sv
module sdseq_top_tb;
    localparam int DW = 32;
    localparam int RW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          arg_wr = 1'b0;
    logic [DW-1:0] arg_wdata = '0;
    logic          xfer_zero = 1'b0;
    logic          card_req_valid;
    logic          card_req_ready = 1'b1;
    logic [5:0]    card_idx;
    logic [DW-1:0] card_arg;
    logic          card_rsp_valid = 1'b0;
    logic          card_rsp_err = 1'b0;
    logic [4:0]    card_rsp_len = '0;
    logic [RW-1:0] card_rsp_data = '0;
    logic [DW-1:0] cmd_word, cmd_arg;
    logic [RW-1:0] rsp_words;
    logic          busy;
    logic [15:0]   sts_set;

    always #10 clk = ~clk;

    sdseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata), .xfer_zero(xfer_zero),
        .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
        .card_idx(card_idx), .card_arg(card_arg), .card_rsp_valid(card_rsp_valid),
        .card_rsp_err(card_rsp_err), .card_rsp_len(card_rsp_len),
        .card_rsp_data(card_rsp_data), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
        .rsp_words(rsp_words), .busy(busy), .sts_set(sts_set)
    );

    localparam logic [DW-1:0] LOAD = 32'h8000_0000;
    localparam logic [DW-1:0] CLKC = 32'h0020_0000;
    localparam logic [DW-1:0] ASTP = 32'h0000_1000;
    localparam logic [DW-1:0] RLNG = 32'h0000_0080;
    localparam logic [DW-1:0] REXP = 32'h0000_0040;
    localparam logic [RW-1:0] PAT  = 128'h11223344_55667788_99AABBCC_DDEEFF00;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // card model configuration and observations
    logic          cfg_err = 1'b0;
    logic [4:0]    cfg_len = 5'd4;
    logic [RW-1:0] cfg_data = PAT;
    bit            rsp_pend = 1'b0;
    int            n_req = 0;
    logic [5:0]    seen_idx = '0;
    logic [DW-1:0] seen_arg = '0;
    int            n_done = 0, n_norsp = 0, n_auto = 0;
    int            n_overlap = 0;

    always @(negedge clk) begin
        card_rsp_valid = 1'b0;
        if (rsp_pend) begin
            card_rsp_valid = 1'b1;
            card_rsp_err   = cfg_err;
            card_rsp_len   = cfg_len;
            card_rsp_data  = cfg_data;
            rsp_pend       = 1'b0;
        end else if (rst_n && card_req_valid && card_req_ready) begin
            n_req++;
            seen_idx = card_idx;
            seen_arg = card_arg;
            rsp_pend = 1'b1;
        end
        if (rst_n) begin
            if (sts_set[2]) n_done++;
            if (sts_set[1]) n_norsp++;
            if (sts_set[14]) n_auto++;
            if (sts_set[2] && sts_set[1]) n_overlap++;
        end
    end

    task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [DW-1:0] v);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic write_arg(input logic [DW-1:0] v);
        @(negedge clk);
        arg_wr = 1'b1; arg_wdata = v;
        @(negedge clk);
        arg_wr = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 40 && (busy || rsp_pend); i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R12 cmd_word", cmd_word, 0);
        check("R12 cmd_arg", cmd_arg, 0);
        check("R12 rsp_words", rsp_words, 0);
        check("R12 busy/valid/sts", {busy, card_req_valid, sts_set}, 0);
    endtask

    task automatic t_short();
        int r0 = n_req, d0 = n_done;
        cfg_err = 0; cfg_len = 5'd4;
        write_arg(32'hCAFE_0001);
        write_cmd(LOAD | REXP | 32'd17);
        settle();
        check("R1 request count", 128'(n_req - r0), 1);
        check("R1 card idx", 128'(seen_idx), 17);
        check("R1 card arg", 128'(seen_arg), 128'h CAFE_0001);
        check("R1 load bit cleared", cmd_word, REXP | 32'd17);
        check("R3 short image", rsp_words, {96'h0, 32'h11223344});
        check("R3 done pulse", 128'(n_done - d0), 1);
    endtask

    task automatic t_long();
        int d0 = n_done;
        cfg_len = 5'd16;
        write_cmd(LOAD | REXP | RLNG | 32'd2);
        settle();
        check("R4 long image", rsp_words, PAT);
        check("R4 done pulse", 128'(n_done - d0), 1);
    endtask

    task automatic t_bad();
        int d0 = n_done, e0 = n_norsp;
        cfg_len = 5'd16;
        write_cmd(LOAD | REXP | 32'd3);       // short asked, 16 returned
        settle();
        cfg_len = 5'd4; cfg_data = ~PAT;
        write_cmd(LOAD | REXP | RLNG | 32'd9); // long asked, 4 returned
        settle();
        cfg_err = 1;
        write_cmd(LOAD | REXP | 32'd5);       // card silent
        settle();
        cfg_err = 0;
        check("R5 no-response pulses", 128'(n_norsp - e0), 3);
        check("R5 no done pulses", 128'(n_done - d0), 0);
        check("R5 regs unchanged", rsp_words, PAT);
        check("R11 bits 1 and 2 never together", 128'(n_overlap), 0);
    endtask

    task automatic t_norsp_expected();
        int d0 = n_done;
        cfg_len = 5'd7;
        write_cmd(LOAD | 32'd0);
        settle();
        check("R6 done pulse", 128'(n_done - d0), 1);
        check("R6 regs unchanged", rsp_words, PAT);
        cfg_data = PAT;
    endtask

    task automatic t_clkchg();
        int r0 = n_req, d0 = n_done;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = LOAD | CLKC;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R2 pulse one cycle after write", 128'(sts_set[2]), 1);
        @(negedge clk);
        check("R11 pulse lasts one cycle", 128'(sts_set[2]), 0);
        settle();
        check("R2 no card request", 128'(n_req - r0), 0);
        check("R2 done count", 128'(n_done - d0), 1);
    endtask

    task automatic t_busy_ignore();
        int r0 = n_req;
        logic [5:0] idx_at_stall;
        cfg_len = 5'd4;
        card_req_ready = 1'b0;
        write_arg(32'h0000_00A5);
        write_cmd(LOAD | REXP | 32'd21);
        write_cmd(LOAD | REXP | 32'd33);
        write_arg(32'h0000_005A);
        idx_at_stall = card_idx;
        repeat (2) @(negedge clk);
        check("R10 held during stall", {card_req_valid, card_idx, card_arg},
              {1'b1, 6'd21, 32'h0000_00A5});
        check("R10 idx stable", 128'(idx_at_stall), 21);
        card_req_ready = 1'b1;
        settle();
        check("R9 single request", 128'(n_req - r0), 1);
        check("R9 cmd ignored", cmd_word, REXP | 32'd21);
        check("R9 arg ignored", cmd_arg, 32'h0000_00A5);
        check("R9 idx sent", 128'(seen_idx), 21);
    endtask

    task automatic t_autostop();
        int r0 = n_req, a0 = n_auto, d0 = n_done;
        cfg_len = 5'd4;
        write_arg(32'h0000_DEAD);
        write_cmd(LOAD | ASTP | REXP | 32'd18);
        settle();
        @(negedge clk); xfer_zero = 1'b1;
        @(negedge clk); xfer_zero = 1'b0;
        settle();
        check("R7 two requests", 128'(n_req - r0), 2);
        check("R7 stop idx", 128'(seen_idx), 12);
        check("R7 stop arg", 128'(seen_arg), 0);
        check("R7 auto pulse", 128'(n_auto - a0), 1);
        check("R7 done pulses", 128'(n_done - d0), 2);
        check("R7 cmd restored", cmd_word, ASTP | REXP | 32'd18);
        check("R7 arg restored", cmd_arg, 32'h0000_DEAD);
    endtask

    task automatic t_autostop_off();
        int r0 = n_req, a0 = n_auto;
        write_cmd(LOAD | REXP | 32'd18);
        settle();
        @(negedge clk); xfer_zero = 1'b1;
        @(negedge clk); xfer_zero = 1'b0;
        settle();
        check("R8 no stop request", 128'(n_req - r0), 1);
        check("R8 no auto pulse", 128'(n_auto - a0), 0);
        check("R8 idle", 128'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_short();
        t_long();
        t_bad();
        t_norsp_expected();
        t_clkchg();
        t_busy_ignore();
        t_autostop();
        t_autostop_off();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule